// File: doc/BRIEF.md
# Command-Phase Handshake Sequencer

This block runs the byte-level handshake between a host and a byte-oriented controller. The controller moves through three phases: command, execution and result. A host starts a command by writing an opcode. The sequencer looks up how many parameter bytes that opcode needs and takes them one at a time. It paces every byte through a "ready" bit and a "direction" bit in an 8-bit status word that the host polls. After each accepted byte, the ready bit stays low until a downstream engine pulses "byte processed". When the last parameter byte has been processed, the sequencer enters the execution phase and enables the data buffer. An unknown opcode sends the sequencer straight to the result phase, where a single error status byte waits to be read.

The execution engine ends its work with a done pulse and a result-byte count. The host then reads that many result bytes, and the last read returns the sequencer to the command phase. There are two ways to return the core to its idle state. The first is a sticky hold-reset bit that a pin reset sets and that only a host write clears. The second is a one-shot reset that releases itself one cycle later. While the hold-reset bit is set, the core stays in reset no matter what the one-shot reset does.

Top module: `cmd_handshake_seq`

## Requirements
- R1: After a pin reset, `hold_rst_o` is 1, `msr_o` is 8'h00, `phase_o` is 2'b00 (command) and `cmd_code_o` is 8'h00. The cycle after the host writes 0 to the hold bit, `msr_o` reads 8'h80: ready bit 7 is 1 and direction bit 6 is 0.
- R2: A byte write is accepted only while `msr_o[7]`=1 and `msr_o[6]`=0. A write attempted at any other time changes neither the parameter count nor the latched opcode.
- R3: The cycle after an accepted write, `msr_o[7]` is 0. It stays 0 until `byte_done_i` is pulsed, and the cycle after that pulse it shows the outcome of the processing.
- R4: The supported opcodes and their parameter counts are: 8'h08→0, 8'h04→1, 8'h03→2, 8'h13→3, 8'h0D→5, 8'h06→8. The ready bit comes back for each remaining parameter byte. Once the last byte has been processed, `phase_o` becomes 2'b01 (execution) and `msr_o` reads 8'h00.
- R5: Any other opcode is illegal. Once it has been processed, `phase_o` becomes 2'b10 (result), `msr_o` reads 8'hC0 and `rd_data_o` reads 8'h80. One host read returns the block to the command phase, and writes made during the result phase are ignored.
- R6: `fifo_en_o` is 1 only in the execution phase and is 0 throughout the command phase.
- R7: When `exec_done_i` is pulsed in the execution phase with a count N≥1, the block enters the result phase with `res_idx_o`=0 and `msr_o`=8'hC0. In that phase `rd_data_o` equals `res_byte_i`, each read advances `res_idx_o` by one, and the N-th read returns the block to the command phase. With N=0, the block goes straight back to the command phase.
- R8: A one-cycle pulse on `self_rst_set_i` makes `msr_o` read 8'h00 for exactly one cycle, after which the core is idle in the command phase (8'h80) without any host action.
- R9: While `hold_rst_o` is 1, the core is held in reset: `msr_o` is 8'h00, `fifo_en_o` is 0 and writes are ignored. A one-shot reset that ends during this time does not release the core; only writing 0 to the hold bit does.
- R10: `cmd_code_o` holds the last accepted opcode through its parameters and execution.
- R11: A `byte_done_i` pulse outside the wait-for-processing state, or an `exec_done_i` pulse outside the execution phase, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high pin reset |
| wr_stb_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host command or parameter byte |
| rd_stb_i | input | 1 | Host result-byte read strobe |
| msr_o | output | 8 | Status word: bit 7 ready, bit 6 direction, other bits 0 |
| rd_data_o | output | 8 | Result byte presented to the host |
| byte_done_i | input | 1 | Pulse: the last accepted byte has been processed |
| exec_done_i | input | 1 | Pulse: execution has finished |
| exec_res_cnt_i | input | 4 | Number of result bytes that come with `exec_done_i` |
| res_byte_i | input | 8 | Result byte supplied by the execution engine |
| res_idx_o | output | 4 | Index of the result byte being presented |
| cmd_code_o | output | 8 | Latched opcode |
| phase_o | output | 2 | 00 command, 01 execution, 10 result |
| fifo_en_o | output | 1 | Data buffer enable |
| hold_rst_wr_i | input | 1 | Host write strobe for the hold-reset bit |
| hold_rst_val_i | input | 1 | Value written to the hold-reset bit |
| self_rst_set_i | input | 1 | Host request for the one-shot reset |
| hold_rst_o | output | 1 | Current value of the hold-reset bit |

## Verification
On every cycle, the assertions check four things. The ready bit is low in the cycle after an accepted write. It stays low while processing is outstanding. The direction bit is set only in the result phase, and the buffer enable is off in the command phase. They also check that a set hold bit forces the status word to zero and that the remaining-parameter count and result index stay in range. Other behaviours only the bench scenarios can show. These are the exact parameter count for each opcode and the single-byte error result. They also include the one-cycle length of the one-shot reset, the fact that the hold bit takes precedence over it, and the rejection of writes and strobes that arrive at the wrong time.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int BYTE_W        = 8;
    localparam int MSR_READY_BIT = 7;
    localparam int MSR_DIR_BIT   = 6;
    localparam logic [BYTE_W-1:0] ERR_STATUS = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PARAM,
        ST_EXEC,
        ST_RESULT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CMD    = 2'b00,
        PH_EXEC   = 2'b01,
        PH_RESULT = 2'b10
    } phase_e;

    typedef struct packed {
        logic       legal;
        logic [3:0] nparam;
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(logic [BYTE_W-1:0] code);
        cmd_info_t info;
        info = '{legal: 1'b1, nparam: 4'd0};
        case (code)
            8'h08:   info.nparam = 4'd0;
            8'h04:   info.nparam = 4'd1;
            8'h03:   info.nparam = 4'd2;
            8'h13:   info.nparam = 4'd3;
            8'h0D:   info.nparam = 4'd5;
            8'h06:   info.nparam = 4'd8;
            default: info.legal  = 1'b0;
        endcase
        return info;
    endfunction

    function automatic phase_e phase_of(seq_state_e s);
        case (s)
            ST_EXEC:   return PH_EXEC;
            ST_RESULT: return PH_RESULT;
            default:   return PH_CMD;
        endcase
    endfunction

endpackage

// File: rtl/cmdseq_len_lut.sv
module cmdseq_len_lut
    import cmdseq_pkg::*;
#(
    parameter int PCNT_W = 4
) (
    input  logic [BYTE_W-1:0] code_i,
    output logic              legal_o,
    output logic [PCNT_W-1:0] nparam_o
);
    cmd_info_t info;

    always_comb begin
        info     = decode_cmd(code_i);
        legal_o  = info.legal;
        nparam_o = PCNT_W'(info.nparam);
    end
endmodule

// File: rtl/cmdseq_rst_merge.sv
module cmdseq_rst_merge (
    input  logic clk,
    input  logic rst,
    input  logic hold_wr_i,
    input  logic hold_val_i,
    input  logic self_set_i,
    output logic hold_o,
    output logic core_rst_o
);
    logic hold_q;
    logic self_q;

    // sticky bit: set by pin reset, changed only by host write
    always_ff @(posedge clk) begin
        if (rst)            hold_q <= 1'b1;
        else if (hold_wr_i) hold_q <= hold_val_i;
    end

    // one-shot: lives for a single cycle unless requested again
    always_ff @(posedge clk) begin
        if (rst) self_q <= 1'b0;
        else     self_q <= self_set_i;
    end

    assign hold_o     = hold_q;
    assign core_rst_o = rst | hold_q | self_q;

    a_r8_self_release: assert property (@(posedge clk) disable iff (rst)
        (self_q && !self_set_i && !hold_q && !hold_wr_i) |=> !core_rst_o)
        else $error("one-shot reset did not release");
endmodule

// File: rtl/cmdseq_res_ptr.sv
module cmdseq_res_ptr #(
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [RES_W-1:0] load_cnt_i,
    input  logic             adv_i,
    input  logic             active_i,
    output logic [RES_W-1:0] idx_o,
    output logic             last_o
);
    logic [RES_W-1:0] cnt_q;
    logic [RES_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_cnt_i;
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + RES_W'(1);
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == cnt_q - RES_W'(1));

    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        active_i |-> (idx_q < cnt_q))
        else $error("result index beyond count");
endmodule

// File: rtl/cmd_handshake_seq.sv
module cmd_handshake_seq
    import cmdseq_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int RES_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              rd_stb_i,
    output logic [BYTE_W-1:0] msr_o,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              byte_done_i,
    input  logic              exec_done_i,
    input  logic [RES_W-1:0]  exec_res_cnt_i,
    input  logic [BYTE_W-1:0] res_byte_i,
    output logic [RES_W-1:0]  res_idx_o,
    output logic [BYTE_W-1:0] cmd_code_o,
    output logic [1:0]        phase_o,
    output logic              fifo_en_o,
    input  logic              hold_rst_wr_i,
    input  logic              hold_rst_val_i,
    input  logic              self_rst_set_i,
    output logic              hold_rst_o
);
    localparam int PCNT_W = $clog2(MAX_PARAMS + 1);

    seq_state_e        state_q;
    logic [PCNT_W-1:0] rem_q;
    logic              legal_q;
    logic              err_q;
    logic [BYTE_W-1:0] code_q;
    logic              core_rst;
    logic              lut_legal;
    logic [PCNT_W-1:0] lut_nparam;
    logic              rqm, dio, acc_wr, acc_rd;
    logic              ptr_load, ptr_last;
    logic [RES_W-1:0]  ptr_cnt;

    cmdseq_rst_merge u_rst (
        .clk        (clk),
        .rst        (rst),
        .hold_wr_i  (hold_rst_wr_i),
        .hold_val_i (hold_rst_val_i),
        .self_set_i (self_rst_set_i),
        .hold_o     (hold_rst_o),
        .core_rst_o (core_rst)
    );

    cmdseq_len_lut #(.PCNT_W(PCNT_W)) u_lut (
        .code_i   (wr_data_i),
        .legal_o  (lut_legal),
        .nparam_o (lut_nparam)
    );

    // status word and handshake qualifiers
    always_comb begin
        rqm    = !core_rst && (state_q == ST_IDLE || state_q == ST_PARAM ||
                               state_q == ST_RESULT);
        dio    = !core_rst && (state_q == ST_RESULT);
        acc_wr = wr_stb_i && rqm && !dio;
        acc_rd = rd_stb_i && rqm && dio;
        msr_o  = '0;
        msr_o[MSR_READY_BIT] = rqm;
        msr_o[MSR_DIR_BIT]   = dio;
    end

    // result pointer loading: illegal opcode yields one byte
    always_comb begin
        ptr_load = 1'b0;
        ptr_cnt  = exec_res_cnt_i;
        if (!core_rst && state_q == ST_WAIT && byte_done_i && !legal_q) begin
            ptr_load = 1'b1;
            ptr_cnt  = RES_W'(1);
        end else if (!core_rst && state_q == ST_EXEC && exec_done_i &&
                     exec_res_cnt_i != '0) begin
            ptr_load = 1'b1;
        end
    end

    cmdseq_res_ptr #(.RES_W(RES_W)) u_ptr (
        .clk        (clk),
        .rst        (core_rst),
        .load_i     (ptr_load),
        .load_cnt_i (ptr_cnt),
        .adv_i      (acc_rd),
        .active_i   (state_q == ST_RESULT),
        .idx_o      (res_idx_o),
        .last_o     (ptr_last)
    );

    always_ff @(posedge clk) begin
        if (core_rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            legal_q <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (acc_wr) begin
                    code_q  <= wr_data_i;
                    legal_q <= lut_legal;
                    rem_q   <= lut_nparam;
                    state_q <= ST_WAIT;
                end
                ST_PARAM: if (acc_wr) begin
                    rem_q   <= rem_q - PCNT_W'(1);
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (byte_done_i) begin
                    if (!legal_q) begin
                        err_q   <= 1'b1;
                        state_q <= ST_RESULT;
                    end else if (rem_q == '0) begin
                        state_q <= ST_EXEC;
                    end else begin
                        state_q <= ST_PARAM;
                    end
                end
                ST_EXEC: if (exec_done_i) begin
                    err_q   <= 1'b0;
                    state_q <= (exec_res_cnt_i == '0) ? ST_IDLE : ST_RESULT;
                end
                ST_RESULT: if (acc_rd && ptr_last) begin
                    err_q   <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_data_o  = err_q ? ERR_STATUS : res_byte_i;
    assign cmd_code_o = code_q;
    assign phase_o    = phase_of(state_q);
    assign fifo_en_o  = !core_rst && (state_q == ST_EXEC);

    a_r3_drop_after_write: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !msr_o[MSR_READY_BIT])
        else $error("ready bit not dropped after write");

    a_r3_low_until_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !byte_done_i && !core_rst) |=> !msr_o[MSR_READY_BIT])
        else $error("ready bit raised before processing");

    a_r5_dir_only_result: assert property (@(posedge clk) disable iff (rst)
        msr_o[MSR_DIR_BIT] |-> (phase_o == PH_RESULT))
        else $error("direction bit outside result phase");

    a_r6_fifo_off_cmd: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_CMD) |-> !fifo_en_o)
        else $error("buffer enabled in command phase");

    a_r9_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        hold_rst_o |-> (msr_o == '0 && !fifo_en_o))
        else $error("core active while hold bit set");

    a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
        rem_q <= PCNT_W'(MAX_PARAMS))
        else $error("parameter count out of range");
endmodule

// File: tb/cmd_handshake_seq_tb_top.sv
module cmd_handshake_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 0, rd_stb = 0, byte_done = 0, exec_done = 0;
    logic [7:0] wr_data = 0, res_byte = 0;
    logic [3:0] exec_cnt = 0;
    logic       hold_wr = 0, hold_val = 0, self_set = 0;
    logic [7:0] msr, rd_data, cmd_code;
    logic [3:0] res_idx;
    logic [1:0] phase;
    logic       fifo_en, hold_rst;
    int         n_chk = 0, n_bad = 0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    cmd_handshake_seq dut_i (
        .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
        .rd_stb_i(rd_stb), .msr_o(msr), .rd_data_o(rd_data),
        .byte_done_i(byte_done), .exec_done_i(exec_done),
        .exec_res_cnt_i(exec_cnt), .res_byte_i(res_byte), .res_idx_o(res_idx),
        .cmd_code_o(cmd_code), .phase_o(phase), .fifo_en_o(fifo_en),
        .hold_rst_wr_i(hold_wr), .hold_rst_val_i(hold_val),
        .self_rst_set_i(self_set), .hold_rst_o(hold_rst)
    );

    // {opcode[15:8], legal[4], count[3:0]}
    localparam logic [15:0] VEC [9] = '{
        16'h0810, 16'h0411, 16'h0312, 16'h1313, 16'h0D15,
        16'h0618, 16'hFF00, 16'h0000, 16'h0700
    };

    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask
    task automatic wr_byte(logic [7:0] b);
        wr_stb = 1; wr_data = b; step(); wr_stb = 0;
    endtask
    task automatic done_pulse();
        byte_done = 1; step(); byte_done = 0;
    endtask
    task automatic rd_pulse();
        rd_stb = 1; step(); rd_stb = 0;
    endtask
    task automatic xdone(logic [3:0] n);
        exec_cnt = n; exec_done = 1; step(); exec_done = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 0; step();
        chk("R1 hold after pin reset", hold_rst, 1);
        chk("R1 msr in reset", msr, 8'h00);
        chk("R1 phase in reset", phase, 2'b00);
        chk("R6 fifo in reset", fifo_en, 0);
        wr_byte(8'h13);
        chk("R9 write ignored while held", cmd_code, 8'h00);
        hold_wr = 1; hold_val = 0; step(); hold_wr = 0;
        chk("R1 ready after hold cleared", msr, 8'h80);
        chk("R1 opcode cleared", cmd_code, 8'h00);

        foreach (VEC[i]) begin
            logic [7:0] code;
            logic       legal;
            logic [3:0] n;
            logic [3:0] rc;
            code = VEC[i][15:8]; legal = VEC[i][4]; n = VEC[i][3:0];
            wr_byte(code);
            chk("R3 ready low after opcode", msr, 8'h00);
            step();
            chk("R3 ready low while pending", msr, 8'h00);
            done_pulse();
            if (!legal) begin
                chk("R5 illegal phase", phase, 2'b10);
                chk("R5 illegal msr", msr, 8'hC0);
                chk("R5 error byte", rd_data, 8'h80);
                wr_byte(8'h55);
                chk("R5 write ignored in result", msr, 8'hC0);
                rd_pulse();
                chk("R5 back to command", phase, 2'b00);
                chk("R5 ready after error read", msr, 8'h80);
            end else begin
                for (int p = 0; p < int'(n); p++) begin
                    chk("R4 param request", msr, 8'h80);
                    chk("R6 fifo off in command", fifo_en, 0);
                    wr_byte(8'(p + 1));
                    chk("R3 ready low after param", msr, 8'h00);
                    done_pulse();
                end
                chk("R4 execution phase", phase, 2'b01);
                chk("R4 msr in execution", msr, 8'h00);
                chk("R6 fifo on in execution", fifo_en, 1);
                chk("R10 opcode held", cmd_code, code);
                rc = 4'((int'(n) % 3) + 1);
                xdone(rc);
                chk("R7 result phase", phase, 2'b10);
                chk("R7 result msr", msr, 8'hC0);
                for (int k = 0; k < int'(rc); k++) begin
                    chk("R7 result index", res_idx, k);
                    res_byte = 8'(8'h40 + k); #1;
                    chk("R7 result byte", rd_data, 8'(8'h40 + k));
                    rd_pulse();
                end
                chk("R7 command after reads", phase, 2'b00);
                chk("R7 ready after reads", msr, 8'h80);
            end
        end

        // R2: write while ready low is not counted
        wr_byte(8'h03);
        wr_byte(8'hAA);
        done_pulse();
        wr_byte(8'h01); done_pulse();
        chk("R2 extra write not counted", msr, 8'h80);
        chk("R2 opcode kept", cmd_code, 8'h03);
        // R11: stray processed pulse in parameter wait-for-write state
        done_pulse();
        chk("R11 stray done in param", msr, 8'h80);
        wr_byte(8'h02); done_pulse();
        chk("R2 exec after true count", phase, 2'b01);
        xdone(4'd0);
        chk("R7 zero count to command", phase, 2'b00);
        chk("R7 zero count ready", msr, 8'h80);

        // R11: stray pulses in idle
        done_pulse();
        chk("R11 stray done idle", msr, 8'h80);
        xdone(4'd2);
        chk("R11 stray exec done", phase, 2'b00);

        // R8: one-shot reset mid-command
        wr_byte(8'h03); done_pulse();
        chk("R8 setup param state", msr, 8'h80);
        self_set = 1; step(); self_set = 0;
        chk("R8 core reset one cycle", msr, 8'h00);
        step();
        chk("R8 self released", msr, 8'h80);
        chk("R8 opcode cleared", cmd_code, 8'h00);
        wr_byte(8'h08); done_pulse();
        chk("R8 fresh opcode executes", phase, 2'b01);

        // R9: hold during execution, precedence over one-shot
        hold_wr = 1; hold_val = 1; step(); hold_wr = 0;
        chk("R9 hold stops fifo", fifo_en, 0);
        chk("R9 hold msr", msr, 8'h00);
        self_set = 1; step(); self_set = 0;
        step(); step();
        chk("R9 one-shot does not release", msr, 8'h00);
        chk("R9 hold bit kept", hold_rst, 1);
        hold_wr = 1; hold_val = 0; step(); hold_wr = 0;
        chk("R9 released by host", msr, 8'h80);
        chk("R9 phase after release", phase, 2'b00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule